// File: doc/BRIEF.md
# Register-Driven I2C Master Sequencer

This block is a single-master I2C controller that performs one whole bus transaction each time the host pulses a go strobe. The host supplies a 24-bit word made of three bytes. The top byte goes out first, its bits most significant first. Bit 0 of that top byte is the read/write flag. When the flag is 0, the block writes two or three bytes, as chosen by a byte-count select. When the flag is 1, it sends the top byte, clocks in one byte from the slave and places that byte in the low byte of the returned word.

The bus lines are open-drain. Each line has an output that, when high, pulls the line low. SDA also has a sampled input. SCL is never stretched by the slave, so it has no input. The bit rate comes from the system clock through one of two quarter-bit dividers, chosen by a rate select. At the default settings on a 33.33 MHz clock, these give about 99.2 kHz and 396.8 kHz. Both rates scale in proportion to the system clock.

When the frame is complete, the block raises a one-cycle interrupt pulse and updates an acknowledge-status bit.

Top module: `i2c_seq_top`

## Requirements
- R1: After reset, busy, irq and ack_ok are 0, and both scl_oe and sda_oe are 0, so both lines are released. The lines stay released whenever busy is 0.
- R2: One SCL period is 4×QDIV_SLOW clocks when fast_sel=0 at go, and 4×QDIV_FAST clocks when fast_sel=1. The period is measured from one SCL rising edge to the next.
- R3: Each transaction begins with exactly one START, in which SDA falls while SCL is high. It ends with exactly one STOP, in which SDA rises while SCL is high.
- R4: Between START and STOP, SDA changes only while SCL is low. No extra START or STOP appears.
- R5: The bytes go out MSB first, in the order wdata[23:16], then wdata[15:8], then wdata[7:0]. With wdata[16]=0, w3_sel=0 sends 2 bytes and w3_sel=1 sends 3 bytes. Each byte is followed by an acknowledge slot in which SDA is released. After a write, rdata equals wdata.
- R6: With wdata[16]=1, the block sends wdata[23:16] and its acknowledge slot. It then releases SDA for 8 clocked bits and for a ninth bit, which is a NACK seen as SDA high. The 8 bits read MSB first set rdata[7:0], and rdata[23:8] equals wdata[23:8].
- R7: ack_ok is 1 after completion only if SDA was low in every expected acknowledge slot. A missing acknowledge does not shorten the frame: all bits and the STOP are still sent.
- R8: Completion gives irq high for exactly one clock. busy is 0 in that same cycle, and rdata and ack_ok are already valid. busy is 1 from the cycle after an accepted go.
- R9: A go while busy is 1 is ignored. The running frame keeps its data, byte count and rate, and only one irq occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdata | input | 24 | Transaction word; bit 16 is the read/write flag |
| w3_sel | input | 1 | For a write, 1 sends three bytes and 0 sends two |
| fast_sel | input | 1 | 1 selects the fast divider, 0 the slow one |
| go | input | 1 | Start strobe; only honoured while idle |
| busy | output | 1 | A transaction is in progress |
| irq | output | 1 | One-cycle completion pulse |
| ack_ok | output | 1 | 1 if every expected acknowledge was received |
| rdata | output | 24 | Latched word; the low byte holds the read result |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
A wrong byte or bit counter shows up on the bus itself. The number of clocked bits changes, or SDA moves while SCL is high. Either one gives an extra START or STOP within the same frame. A quarter-phase or divider fault changes the measured SCL period from the first bit on. A sampling or acknowledge-flag fault appears at the completion pulse, in rdata[7:0] or ack_ok, on the cycle irq rises.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
    localparam int SEQ_DW     = 24;
    localparam int SEQ_BYTE   = 8;
    localparam int SEQ_RW_BIT = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BIT   = 2'd2,
        ST_STOP  = 2'd3
    } seq_st_e;
endpackage

// File: rtl/i2c_seq_qtick.sv
module i2c_seq_qtick #(
    parameter int QDIV_SLOW = 84,
    parameter int QDIV_FAST = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fast,
    output logic tick
);
    localparam int QMAX = (QDIV_SLOW > QDIV_FAST) ? QDIV_SLOW : QDIV_FAST;
    localparam int CW   = $clog2(QMAX + 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(QDIV_SLOW - 1);
    localparam logic [CW-1:0] LIM_FAST = CW'(QDIV_FAST - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim   = fast ? LIM_FAST : LIM_SLOW;
        tick  = en && (cnt_q == lim);
        cnt_d = cnt_q;
        if (!en)
            cnt_d = '0;
        else if (cnt_q == lim)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
endmodule

// File: rtl/i2c_seq_frame.sv
module i2c_seq_frame
    import i2c_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  logic [SEQ_DW-1:0] wdata,
    input  logic              w3_sel,
    input  logic              fast_sel,
    input  logic              sda_i,
    output logic              busy,
    output logic              fast,
    output logic              irq,
    output logic              ack_ok,
    output logic [SEQ_DW-1:0] rdata,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam logic [3:0] ACK_POS = 4'(SEQ_BYTE);

    typedef struct packed {
        seq_st_e           st;
        logic [1:0]        q;
        logic [3:0]        pos;
        logic [1:0]        byt;
        logic [SEQ_DW-1:0] sh;
        logic [SEQ_DW-1:0] dat;
        logic              w3;
        logic              rd;
        logic              fast;
        logic              fail;
        logic              busy;
        logic              irq;
        logic              ack_ok;
    } fr_t;

    fr_t  r_d, r_q;
    logic last_byte;
    logic rx_byte;

    always_comb begin
        r_d       = r_q;
        r_d.irq   = 1'b0;
        last_byte = r_q.rd ? (r_q.byt == 2'd1)
                           : (r_q.w3 ? (r_q.byt == 2'd2) : (r_q.byt == 2'd1));
        rx_byte   = r_q.rd && (r_q.byt == 2'd1);
        case (r_q.st)
            ST_IDLE: begin
                if (go) begin
                    r_d.st   = ST_START;
                    r_d.q    = 2'd0;
                    r_d.pos  = 4'd0;
                    r_d.byt  = 2'd0;
                    r_d.sh   = wdata;
                    r_d.dat  = wdata;
                    r_d.w3   = w3_sel;
                    r_d.rd   = wdata[SEQ_RW_BIT];
                    r_d.fast = fast_sel;
                    r_d.fail = 1'b0;
                    r_d.busy = 1'b1;
                end
            end
            ST_START: begin
                if (tick) begin
                    r_d.q = r_q.q + 2'd1;
                    if (r_q.q == 2'd3) r_d.st = ST_BIT;
                end
            end
            ST_BIT: begin
                if (tick) begin
                    r_d.q = r_q.q + 2'd1;
                    if (r_q.q == 2'd1) begin
                        if (r_q.pos == ACK_POS) begin
                            if (!rx_byte && sda_i) r_d.fail = 1'b1;
                        end else if (rx_byte) begin
                            r_d.dat[SEQ_BYTE-1:0] = {r_q.dat[SEQ_BYTE-2:0], sda_i};
                        end
                    end
                    if (r_q.q == 2'd3) begin
                        if (r_q.pos == ACK_POS) begin
                            r_d.pos = 4'd0;
                            r_d.byt = r_q.byt + 2'd1;
                            if (last_byte) r_d.st = ST_STOP;
                        end else begin
                            r_d.pos = r_q.pos + 4'd1;
                            if (!rx_byte) r_d.sh = {r_q.sh[SEQ_DW-2:0], 1'b0};
                        end
                    end
                end
            end
            default: begin
                if (tick) begin
                    r_d.q = r_q.q + 2'd1;
                    if (r_q.q == 2'd3) begin
                        r_d.st     = ST_IDLE;
                        r_d.busy   = 1'b0;
                        r_d.irq    = 1'b1;
                        r_d.ack_ok = !r_q.fail;
                    end
                end
            end
        endcase
    end

    always_comb begin
        case (r_q.st)
            ST_IDLE:  begin scl_oe = 1'b0;               sda_oe = 1'b0;            end
            ST_START: begin scl_oe = (r_q.q == 2'd3);    sda_oe = r_q.q[1];        end
            ST_BIT: begin
                scl_oe = (r_q.q == 2'd0) || (r_q.q == 2'd3);
                sda_oe = (r_q.pos != ACK_POS && !rx_byte) ? !r_q.sh[SEQ_DW-1] : 1'b0;
            end
            default:  begin scl_oe = (r_q.q == 2'd0);    sda_oe = !r_q.q[1];       end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy   = r_q.busy;
    assign fast   = r_q.fast;
    assign irq    = r_q.irq;
    assign ack_ok = r_q.ack_ok;
    assign rdata  = r_q.dat;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe)); // R1
    AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BIT && $past(r_q.st == ST_BIT) && !scl_oe && $past(!scl_oe))
        |-> $stable(sda_oe)); // R4
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8
    AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy); // R8
    AST_GO_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> busy); // R8
    AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (go && busy) |=> (r_q.rd == $past(r_q.rd) && r_q.w3 == $past(r_q.w3)
                          && fast == $past(fast))); // R9
endmodule

// File: rtl/i2c_seq_top.sv
module i2c_seq_top
    import i2c_seq_pkg::*;
#(
    parameter int QDIV_SLOW = 84,
    parameter int QDIV_FAST = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEQ_DW-1:0] wdata,
    input  logic              w3_sel,
    input  logic              fast_sel,
    input  logic              go,
    output logic              busy,
    output logic              irq,
    output logic              ack_ok,
    output logic [SEQ_DW-1:0] rdata,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_i
);
    logic tick;
    logic fast;

    i2c_seq_qtick #(
        .QDIV_SLOW (QDIV_SLOW),
        .QDIV_FAST (QDIV_FAST)
    ) u_qtick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .fast  (fast),
        .tick  (tick)
    );

    i2c_seq_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .go       (go),
        .wdata    (wdata),
        .w3_sel   (w3_sel),
        .fast_sel (fast_sel),
        .sda_i    (sda_i),
        .busy     (busy),
        .fast     (fast),
        .irq      (irq),
        .ack_ok   (ack_ok),
        .rdata    (rdata),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe)
    );
endmodule

// File: tb/sim_i2c_seq_top.sv
module sim_i2c_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int QS = 10;
    localparam int QF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] wdata = '0;
    logic        w3_sel = 1'b0;
    logic        fast_sel = 1'b0;
    logic        go = 1'b0;
    logic        busy, irq, ack_ok, scl_oe, sda_oe, sda_i;
    logic [23:0] rdata;

    logic        slv_pull = 1'b0;
    logic [2:0]  nack_m = '0;
    logic [7:0]  rbyte = '0;

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 1'b0;

    bit  capt [0:63];
    int  bitcnt = 0, nstart = 0, nstop = 0, nirq = 0;
    int  since_rise = 0, per_min = 0, per_max = 0;
    bit  seen_rise = 1'b0, prev_scl = 1'b1, prev_sda = 1'b1;

    assign sda_i = !sda_oe && !slv_pull;

    i2c_seq_top #(.QDIV_SLOW(QS), .QDIV_FAST(QF)) u0 (
        .clk(clk), .rst_n(rst_n), .wdata(wdata), .w3_sel(w3_sel),
        .fast_sel(fast_sel), .go(go), .busy(busy), .irq(irq),
        .ack_ok(ack_ok), .rdata(rdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .sda_i(sda_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit slave_drive(input int b);
        int  byt;
        bit  rw;
        rw  = capt[7];
        byt = b / 9;
        if (b % 9 == 8) begin
            if (rw ? (byt == 0) : (byt < 3)) return !nack_m[byt];
            return 1'b0;
        end
        if (rw && b >= 9 && b <= 16) return !rbyte[16 - b];
        return 1'b0;
    endfunction

    always @(negedge clk) begin
        bit scl, sda;
        scl = !scl_oe;
        sda = !sda_oe && !slv_pull;
        if (irq) nirq++;
        since_rise++;
        if (scl && prev_scl && prev_sda && !sda) begin nstart++; bitcnt = 0; end
        if (scl && prev_scl && !prev_sda && sda) nstop++;
        if (scl && !prev_scl) begin
            if (seen_rise) begin
                if (since_rise < per_min) per_min = since_rise;
                if (since_rise > per_max) per_max = since_rise;
            end
            seen_rise  = 1'b1;
            since_rise = 0;
            if (bitcnt < 64) capt[bitcnt] = sda;
            bitcnt++;
        end
        if (!scl && prev_scl) slv_pull = slave_drive(bitcnt);
        prev_scl = scl;
        prev_sda = !sda_oe && !slv_pull;
    end

    function automatic logic [7:0] cap_byte(input int k);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[7-i] = capt[9*k + i];
        return v;
    endfunction

    task automatic run(input logic [23:0] d, input bit w3, input bit fst,
                       input logic [2:0] nk, input logic [7:0] rb, input bit poke);
        bit          rw;
        int          nb, t, q;
        bit          exp_ack;
        logic [23:0] exp_rd;
        logic [7:0]  exp_b;
        rw = d[16];
        nb = rw ? 2 : (w3 ? 3 : 2);
        q  = fst ? QF : QS;
        exp_ack = rw ? !nk[0] : ((nk & ((nb == 3) ? 3'b111 : 3'b011)) == 3'b000);
        exp_rd  = rw ? {d[23:8], rb} : d;
        nack_m = nk; rbyte = rb;
        nstart = 0; nstop = 0; nirq = 0; seen_rise = 1'b0;
        per_min = 1 << 30; per_max = 0;
        @(negedge clk);
        wdata = d; w3_sel = w3; fast_sel = fst; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(busy == 1'b1, "R8", "busy after go", busy, 1);
        if (poke) begin
            repeat (150) @(negedge clk);
            wdata = ~d; w3_sel = ~w3; fast_sel = ~fst; go = 1'b1;
            @(negedge clk);
            go = 1'b0;
        end
        t = 0;
        while (!irq && t < 20000) begin @(negedge clk); t++; end
        chk(irq == 1'b1, "R8", "completion irq", irq, 1);
        chk(busy == 1'b0, "R8", "busy low at irq", busy, 0);
        chk(ack_ok == exp_ack, "R7", "ack status", ack_ok, exp_ack);
        chk(rdata == exp_rd, rw ? "R6" : "R5", "rdata", rdata, exp_rd);
        @(negedge clk);
        chk(irq == 1'b0, "R8", "irq one cycle", irq, 0);
        chk(!scl_oe && !sda_oe, "R1", "lines released idle", {scl_oe, sda_oe}, 0);
        repeat (3) @(negedge clk);
        chk(nirq == 1, poke ? "R9" : "R8", "irq count", nirq, 1);
        chk(nstart == 1, "R3", "start count", nstart, 1);
        chk(nstop == 1, "R4", "stop count (no stray edges)", nstop, 1);
        chk(bitcnt == 9*nb + 1, "R7", "clocked bits incl stop", bitcnt, 9*nb + 1);
        for (int k = 0; k < nb; k++) begin
            exp_b = (rw && k == 1) ? rb : d[23 - 8*k -: 8];
            chk(cap_byte(k) == exp_b, (rw && k == 1) ? "R6" : "R5", "bus byte",
                cap_byte(k), exp_b);
        end
        if (rw) chk(capt[17] == 1'b1, "R6", "master nack", capt[17], 1);
        chk(per_min == 4*q && per_max == 4*q, "R2", "scl period",
            per_min, 4*q);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [23:0] rd;
        void'($urandom(32'd1234));
        #(CLK_PERIOD * 3 + 2);
        chk(busy == 1'b0 && irq == 1'b0 && ack_ok == 1'b0, "R1", "reset status",
            {busy, irq, ack_ok}, 0);
        chk(!scl_oe && !sda_oe, "R1", "reset lines", {scl_oe, sda_oe}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!scl_oe && !sda_oe && !busy, "R1", "idle after reset", {scl_oe, sda_oe, busy}, 0);
        run(24'hA4_5C_3E, 1'b0, 1'b0, 3'b000, 8'h00, 1'b0); // R5 two bytes
        run(24'h5A_C3_81, 1'b1, 1'b1, 3'b000, 8'h00, 1'b0); // R5 three bytes
        run(24'hA5_12_34, 1'b0, 1'b0, 3'b000, 8'h96, 1'b0); // R6 read
        run(24'hA5_00_00, 1'b0, 1'b1, 3'b001, 8'h3C, 1'b0); // R6 R7 nack addr
        run(24'h42_77_19, 1'b1, 1'b0, 3'b100, 8'h00, 1'b0); // R7 nack last
        run(24'h42_77_19, 1'b0, 1'b0, 3'b100, 8'h00, 1'b0); // R7 nack beyond count
        run(24'hFF_FE_FF, 1'b0, 1'b0, 3'b000, 8'h00, 1'b0); // R4 dense ones
        run(24'hC8_11_EE, 1'b1, 1'b0, 3'b000, 8'h00, 1'b1); // R9 go ignored
        run(24'hC9_00_00, 1'b0, 1'b1, 3'b000, 8'hF0, 1'b1); // R9 read with poke
        for (int i = 0; i < 16; i++) begin
            logic [2:0] nk;
            rd = 24'($urandom);
            nk[0] = ($urandom % 4) == 0;
            nk[1] = ($urandom % 4) == 0;
            nk[2] = ($urandom % 4) == 0;
            run(rd, 1'($urandom), 1'($urandom), nk, 8'($urandom), 1'b0);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule